// File: doc/BRIEF.md
# Linked-descriptor DMA channel engine

A single-channel DMA engine that moves words from a source to a destination over a simple memory master port. Its transfer plan is a descriptor: four 32-bit words held in a table in memory. The four words are a transfer configuration, a source end address, a destination end address and a pointer to the next descriptor. Software sets the table base, the enable bit and the channel options. It then writes a transfer configuration with its trigger bit set. The engine fetches the channel's table entry at base + 16·CHAN and then runs the transfer. For this first descriptor, word 0 of the entry is ignored, because the configuration just written takes its place.

Addresses in a descriptor name the last element of a transfer, and the count field holds one less than the number of elements. When a configuration asks for reload, the engine fetches the descriptor at the next pointer when it finishes and carries on with it. A chain of descriptors can therefore ping-pong or loop forever with no processor help. An optional peripheral request mode makes each element wait for a request input. Clearing the enable bit stops the channel at the next element boundary.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset the engine is idle: active_o, m_valid_o, done_o and irq_o are low, and prio_o is 0.
- R2: A write to register 3 starts the channel only if all of these hold: bit 0 (valid) is set, bit 2 (trigger) is set, the enable bit (register 0, bit 0) is set, and the channel is idle. The engine then issues four sequential reads at T+0, T+4, T+8 and T+12. T is the base from register 1 with its low 9 bits cleared, plus 16·CHAN. Word 0 is ignored for this first descriptor. Words 1 to 3 give the source end, the destination end and the next pointer.
- R3: The count field (bits 25:16) holds K, and the descriptor moves K+1 elements. Each element is one read at the source followed by one write of the same data word at the destination.
- R4: Element i (for i from 0 to K) uses the address end − (K−i)·stride. The stride is 0 when the increment bit is clear. Otherwise it is 1, 2 or 4 bytes for width code 0, 1 or 2 in bits 5:4. The source increment is bit 6 and the destination increment is bit 7.
- R5: When bit 1 (reload) of the active configuration is set, the last write is followed by four reads at the next pointer. Word 0 of that descriptor becomes the configuration. If its valid bit is clear, the engine goes idle and moves no elements.
- R6: done_o pulses for one cycle each time a descriptor completes. irq_o pulses with it only when bit 3 of that descriptor's configuration is set.
- R7: With peripheral request mode on (register 2, bit 0), no element read starts while dreq_i is low. Descriptor fetches still proceed.
- R8: A write to register 3 that has its valid bit clear, or that arrives while enable is clear, starts nothing.
- R9: Clearing enable while the channel runs stops it at the next element boundary. active_o falls, and no further access is made.
- R10: An access holds m_valid_o, m_addr_o, m_write_o and m_wdata_o stable until m_ready_i is seen. Only one access is outstanding at a time.
- R11: Register 2, bits 6:4, set a priority that appears on prio_o and has no effect on transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 enable, 1 table base, 2 channel options, 3 transfer configuration |
| cfg_wdata | input | 32 | Register write data |
| dreq_i | input | 1 | Peripheral request |
| m_valid_o | output | 1 | Memory access request |
| m_write_o | output | 1 | 1 = write, 0 = read |
| m_addr_o | output | AW | Byte address of the access |
| m_wdata_o | output | 32 | Write data |
| m_ready_i | input | 1 | Access accepted; read data valid in the same cycle |
| m_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle pulse per completed descriptor |
| irq_o | output | 1 | Interrupt pulse for descriptors that request it |
| active_o | output | 1 | Channel busy |
| prio_o | output | 3 | Stored channel priority |

## Verification
On every cycle, the assertions check the bus handshake hold, the single-cycle done pulse and the ordered four-word fetch. They also check that no element read is taken without a request in peripheral mode, that a start needs enable, and that the bus stays silent while idle. The following can only be shown by the bench's scenarios, which compare every accepted access against a behavioural walk of the descriptor chain in memory:
- the end-relative address arithmetic for each width and increment choice
- the K+1 element count
- following and terminating a reload chain
- the element-boundary abort of an endless ping-pong loop
- configurations that are rejected

// File: rtl/dma_pkg.sv
package dma_pkg;
   localparam int XF_VALID  = 0;
   localparam int XF_RELOAD = 1;
   localparam int XF_TRIG   = 2;
   localparam int XF_IRQ    = 3;
   localparam int XF_WID    = 4;
   localparam int XF_SINC   = 6;
   localparam int XF_DINC   = 7;
   localparam int XF_CNT    = 16;
   localparam int XF_CNT_W  = 10;

   typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ELEM, S_READ, S_WRITE} dma_state_e;

   typedef struct packed {
      logic                valid;
      logic                reload;
      logic                irq_en;
      logic [1:0]          width;
      logic                src_inc;
      logic                dst_inc;
      logic [XF_CNT_W-1:0] cnt;
   } xfer_cfg_t;

   function automatic xfer_cfg_t decode_cfg(input logic [31:0] w);
      xfer_cfg_t c;
      c.valid   = w[XF_VALID];
      c.reload  = w[XF_RELOAD];
      c.irq_en  = w[XF_IRQ];
      c.width   = w[XF_WID +: 2];
      c.src_inc = w[XF_SINC];
      c.dst_inc = w[XF_DINC];
      c.cnt     = w[XF_CNT +: XF_CNT_W];
      return c;
   endfunction

   function automatic logic [1:0] width_shift(input logic [1:0] w);
      return (w == 2'd3) ? 2'd2 : w;
   endfunction
endpackage

// File: rtl/dma_regs.sv
module dma_regs
   import dma_pkg::*;
#(
   parameter int AW        = 32,
   parameter int TBL_BYTES = 512
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    addr,
   input  logic [31:0]   wdata,
   input  logic          busy,
   output logic          en,
   output logic [AW-1:0] base,
   output logic          periph,
   output logic [2:0]    prio,
   output logic          trig,
   output logic [31:0]   xfer
);
   localparam logic [AW-1:0] ALIGN_MASK = ~AW'(TBL_BYTES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         base   <= '0;
         periph <= 1'b0;
         prio   <= '0;
         trig   <= 1'b0;
         xfer   <= '0;
      end else begin
         trig <= 1'b0;
         if (we) begin
            case (addr)
               2'd0: en <= wdata[0];
               2'd1: base <= wdata[AW-1:0] & ALIGN_MASK;
               2'd2: begin
                  periph <= wdata[0];
                  prio   <= wdata[6:4];
               end
               default: begin
                  if (wdata[XF_VALID] && wdata[XF_TRIG] && en && !busy && !trig) begin
                     xfer <= wdata;
                     trig <= 1'b1;
                  end
               end
            endcase
         end
      end
   end

   a_r8_trig_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      trig |-> en);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dma_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CNT_W = XF_CNT_W
) (
   input  logic [AW-1:0]    end_addr,
   input  logic [CNT_W-1:0] rem,
   input  logic             inc,
   input  logic [1:0]       width,
   output logic [AW-1:0]    addr
);
   logic [AW-1:0] offset;

   always_comb begin
      offset = AW'(rem) << width_shift(width);
      addr   = inc ? (end_addr - offset) : end_addr;
   end
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
   import dma_pkg::*;
#(
   parameter int AW   = 32,
   parameter int CHAN = 21
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          trig,
   input  logic [31:0]   xfer_in,
   input  logic [AW-1:0] base,
   input  logic          periph,
   input  logic          dreq,
   output logic          m_valid,
   output logic          m_write,
   output logic [AW-1:0] m_addr,
   output logic [31:0]   m_wdata,
   input  logic          m_ready,
   input  logic [31:0]   m_rdata,
   output logic          done,
   output logic          irq,
   output logic          active
);
   localparam int            DESC_BYTES = 16;
   localparam logic [AW-1:0] DESC_OFF   = AW'(CHAN * DESC_BYTES);

   dma_state_e           st;
   xfer_cfg_t            cfg;
   logic [AW-1:0]        ptr, src_end, dst_end, nxt;
   logic [1:0]           idx;
   logic                 first;
   logic [XF_CNT_W-1:0]  rem;
   logic [31:0]          data;
   logic [AW-1:0]        src_a, dst_a;
   logic                 accept;

   dma_addr_gen #(.AW(AW), .CNT_W(XF_CNT_W)) u_src (
      .end_addr(src_end), .rem(rem), .inc(cfg.src_inc), .width(cfg.width), .addr(src_a));
   dma_addr_gen #(.AW(AW), .CNT_W(XF_CNT_W)) u_dst (
      .end_addr(dst_end), .rem(rem), .inc(cfg.dst_inc), .width(cfg.width), .addr(dst_a));

   always_comb begin
      m_valid = (st == S_FETCH) || (st == S_READ) || (st == S_WRITE);
      m_write = (st == S_WRITE);
      m_wdata = data;
      case (st)
         S_FETCH: m_addr = ptr + AW'({idx, 2'b00});
         S_READ:  m_addr = src_a;
         default: m_addr = dst_a;
      endcase
      accept = m_valid && m_ready;
      active = (st != S_IDLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         cfg     <= '0;
         ptr     <= '0;
         src_end <= '0;
         dst_end <= '0;
         nxt     <= '0;
         idx     <= '0;
         first   <= 1'b0;
         rem     <= '0;
         data    <= '0;
         done    <= 1'b0;
         irq     <= 1'b0;
      end else begin
         done <= 1'b0;
         irq  <= 1'b0;
         case (st)
            S_IDLE: if (trig) begin
               cfg   <= decode_cfg(xfer_in);
               ptr   <= base + DESC_OFF;
               idx   <= '0;
               first <= 1'b1;
               st    <= S_FETCH;
            end
            S_FETCH: if (accept) begin
               idx <= idx + 2'd1;
               case (idx)
                  2'd0: if (!first) cfg <= decode_cfg(m_rdata);
                  2'd1: src_end <= m_rdata[AW-1:0];
                  2'd2: dst_end <= m_rdata[AW-1:0];
                  default: begin
                     nxt <= m_rdata[AW-1:0];
                     rem <= cfg.cnt;
                     st  <= cfg.valid ? S_ELEM : S_IDLE;
                  end
               endcase
            end
            S_ELEM: begin
               if (!en) st <= S_IDLE;
               else if (!periph || dreq) st <= S_READ;
            end
            S_READ: if (accept) begin
               data <= m_rdata;
               st   <= S_WRITE;
            end
            default: if (accept) begin
               if (rem == '0) begin
                  done <= 1'b1;
                  irq  <= cfg.irq_en;
                  if (cfg.reload) begin
                     ptr   <= nxt;
                     idx   <= '0;
                     first <= 1'b0;
                     st    <= S_FETCH;
                  end else begin
                     st <= S_IDLE;
                  end
               end else begin
                  rem <= rem - XF_CNT_W'(1);
                  st  <= S_ELEM;
               end
            end
         endcase
      end
   end

   // R10: an unanswered access is held unchanged
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata)));

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2 and R5: the four descriptor words are read in order
   a_r5_fetch_order: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_FETCH && m_ready && idx != 2'd3) |=> (st == S_FETCH && idx == 2'($past(idx) + 2'd1)));

   a_r7_wait_req: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_READ && $past(st) == S_ELEM && periph) |-> $past(dreq));
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
   import dma_pkg::*;
#(
   parameter int AW          = 32,
   parameter int CHAN        = 21,
   parameter int ENTRIES     = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_addr,
   input  logic [31:0]   cfg_wdata,
   input  logic          dreq_i,
   output logic          m_valid_o,
   output logic          m_write_o,
   output logic [AW-1:0] m_addr_o,
   output logic [31:0]   m_wdata_o,
   input  logic          m_ready_i,
   input  logic [31:0]   m_rdata_i,
   output logic          done_o,
   output logic          irq_o,
   output logic          active_o,
   output logic [2:0]    prio_o
);
   localparam int TBL_BYTES = ENTRIES * 16;

   if (CHAN < 0 || CHAN >= ENTRIES) begin : g_bad_chan
      $error("CHAN must index an entry of the descriptor table");
   end
   if ((ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two");
   end
   if (AW < 12 || AW > 32) begin : g_bad_aw
      $error("AW must lie between 12 and 32");
   end

   logic          en, periph, trig, dreq_s;
   logic [AW-1:0] base;
   logic [31:0]   xfer;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign dreq_s = dreq_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh[0] <= 1'b0;
         else        sh[0] <= dreq_i;
      end
      for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[k] <= 1'b0;
            else        sh[k] <= sh[k-1];
         end
      end
      assign dreq_s = sh[SYNC_STAGES-1];
   end

   dma_regs #(.AW(AW), .TBL_BYTES(TBL_BYTES)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .busy(active_o), .en(en), .base(base), .periph(periph), .prio(prio_o),
      .trig(trig), .xfer(xfer));

   dma_ctrl #(.AW(AW), .CHAN(CHAN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .xfer_in(xfer), .base(base),
      .periph(periph), .dreq(dreq_s), .m_valid(m_valid_o), .m_write(m_write_o),
      .m_addr(m_addr_o), .m_wdata(m_wdata_o), .m_ready(m_ready_i), .m_rdata(m_rdata_i),
      .done(done_o), .irq(irq_o), .active(active_o));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !active_o |-> !m_valid_o);
endmodule

// File: tb/tb_dma_chain_engine.sv
module tb_dma_chain_engine;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] TBASE = 32'h200;
   localparam logic [31:0] DESC  = TBASE + 32'd16 * 21;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        dreq_i = 1'b0;
   logic        m_valid_o, m_write_o, done_o, irq_o, active_o;
   logic [31:0] m_addr_o, m_wdata_o, m_rdata_i;
   logic        m_ready_i = 1'b0;
   logic [2:0]  prio_o;

   logic [31:0] mem [0:1023];
   logic [31:0] shadow [0:1023];
   logic [31:0] eq_addr[$];
   logic        eq_wr[$];
   logic [31:0] eq_data[$];
   int nchk = 0, nerr = 0, ntx = 0, ndone = 0, nirq = 0, edone = 0, eirq = 0;
   logic [7:0] lfsr = 8'h5A;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign m_rdata_i = mem[m_addr_o[11:2]];

   dma_chain_engine dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .dreq_i(dreq_i), .m_valid_o(m_valid_o), .m_write_o(m_write_o), .m_addr_o(m_addr_o),
      .m_wdata_o(m_wdata_o), .m_ready_i(m_ready_i), .m_rdata_i(m_rdata_i),
      .done_o(done_o), .irq_o(irq_o), .active_o(active_o), .prio_o(prio_o));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model and per-cycle comparison with the expected access stream
   always begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      m_ready_i = lfsr[0] | lfsr[1];
      #(CLK_PERIOD/4);
      if (rst_n) begin
         if (done_o) ndone++;
         if (irq_o) nirq++;
         if (m_valid_o && m_ready_i) begin
            ntx++;
            if (eq_addr.size() == 0) begin
               chk(1'b0, "R3 unexpected access", m_addr_o, 32'h0);
            end else begin
               chk(m_addr_o == eq_addr[0], "R4 access address", m_addr_o, eq_addr[0]);
               chk(m_write_o == eq_wr[0], "R3 access direction", 32'(m_write_o), 32'(eq_wr[0]));
               if (eq_wr[0])
                  chk(m_wdata_o == eq_data[0], "R3 write data", m_wdata_o, eq_data[0]);
               void'(eq_addr.pop_front());
               void'(eq_wr.pop_front());
               void'(eq_data.pop_front());
            end
            if (m_write_o) mem[m_addr_o[11:2]] = m_wdata_o;
         end
      end
   end

   function automatic logic [31:0] xf(input bit rl, input bit ie, input logic [1:0] w,
                                      input bit si, input bit di, input int k);
      return 32'h5 | (32'(rl) << 1) | (32'(ie) << 3) | (32'(w) << 4) |
             (32'(si) << 6) | (32'(di) << 7) | (32'(k) << 16);
   endfunction

   task automatic push(input logic [31:0] a, input bit w, input logic [31:0] d);
      eq_addr.push_back(a);
      eq_wr.push_back(w);
      eq_data.push_back(d);
   endtask

   // behavioural walk of the descriptor chain over a copy of memory
   task automatic plan(input logic [31:0] cfg0, input int limit);
      logic [31:0] ptr, cfg, se, de, nx, a, b, d, stp;
      bit first;
      int k;
      eq_addr.delete(); eq_wr.delete(); eq_data.delete();
      for (int i = 0; i < 1024; i++) shadow[i] = mem[i];
      ptr = DESC; cfg = cfg0; first = 1; edone = 0; eirq = 0;
      while (eq_addr.size() < limit) begin
         for (int j = 0; j < 4; j++) push(ptr + 32'(4*j), 1'b0, 32'h0);
         if (!first) cfg = shadow[ptr[11:2]];
         se = shadow[ptr[11:2] + 1];
         de = shadow[ptr[11:2] + 2];
         nx = shadow[ptr[11:2] + 3];
         if (!cfg[0]) break;
         k = int'(cfg[25:16]);
         stp = (cfg[5:4] == 2'd0) ? 1 : (cfg[5:4] == 2'd1) ? 2 : 4;
         for (int i = 0; i <= k; i++) begin
            a = cfg[6] ? se - 32'(k - i) * stp : se;
            b = cfg[7] ? de - 32'(k - i) * stp : de;
            d = shadow[a[11:2]];
            push(a, 1'b0, 32'h0);
            push(b, 1'b1, d);
            shadow[b[11:2]] = d;
         end
         edone++;
         if (cfg[3]) eirq++;
         if (!cfg[1]) break;
         ptr = nx; first = 0;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      repeat (4) @(negedge clk);
      while (active_o && n < 20000) begin
         @(negedge clk);
         n++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic set_desc(input logic [31:0] at, input logic [31:0] c, input logic [31:0] se,
                           input logic [31:0] de, input logic [31:0] nx);
      mem[at[11:2]] = c; mem[at[11:2]+1] = se; mem[at[11:2]+2] = de; mem[at[11:2]+3] = nx;
   endtask

   task automatic run_plain(input logic [31:0] c, input string req);
      int d0, i0;
      d0 = ndone; i0 = nirq;
      plan(c, 100000);
      wr(2'd3, c);
      wait_idle();
      chk(eq_addr.size() == 0, req, 32'(eq_addr.size()), 32'h0);
      chk(ndone - d0 == edone, "R6 done count", 32'(ndone - d0), 32'(edone));
      chk(nirq - i0 == eirq, "R6 irq count", 32'(nirq - i0), 32'(eirq));
      chk(active_o == 1'b0, "R3 idle after run", 32'(active_o), 32'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int t0, d0;
      for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 | 32'(i);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!active_o && !m_valid_o && !done_o && !irq_o && prio_o == 3'd0, "R1 reset state",
          {27'h0, active_o, m_valid_o, done_o, irq_o, 1'b0}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      wr(2'd0, 32'h1);
      wr(2'd1, TBASE | 32'h1F);        // R2: low base bits are dropped
      wr(2'd2, 32'h50);
      @(negedge clk);
      chk(prio_o == 3'd5, "R11 priority stored", 32'(prio_o), 32'h5);

      // R2, R3, R4: word copy with both increments, word 0 junk ignored
      set_desc(DESC, 32'hFFFF_FFFF, 32'h80C, 32'hC0C, 32'h0);
      run_plain(xf(0, 1, 2'd2, 1, 1, 3), "R2 fetch and copy of four words");
      for (int i = 0; i < 4; i++)
         chk(mem[(32'hC00 >> 2) + i] == (32'hA500_0000 | 32'((32'h800 >> 2) + i)),
             "R3 destination contents", mem[(32'hC00 >> 2) + i],
             32'hA500_0000 | 32'((32'h800 >> 2) + i));

      // R4: fixed source, half-word stride destination, no interrupt
      set_desc(DESC, 32'h0, 32'h900, 32'hD08, 32'h0);
      run_plain(xf(0, 0, 2'd1, 0, 1, 4), "R4 fixed source, stride two");

      // R4: byte stride on the source side
      set_desc(DESC, 32'h0, 32'h905, 32'hE00, 32'h0);
      run_plain(xf(0, 1, 2'd0, 1, 0, 5), "R4 byte stride source");

      // R3: count zero moves one element
      set_desc(DESC, 32'h0, 32'h840, 32'hC40, 32'h0);
      run_plain(xf(0, 1, 2'd2, 1, 1, 0), "R3 single element");

      // R7: peripheral request mode
      wr(2'd2, 32'h51);
      dreq_i = 1'b0;
      set_desc(DESC, 32'h0, 32'h844, 32'hC80, 32'h0);
      t0 = ntx;
      plan(xf(0, 0, 2'd2, 1, 1, 1), 100000);
      wr(2'd3, xf(0, 0, 2'd2, 1, 1, 1));
      repeat (60) @(negedge clk);
      chk(ntx - t0 == 4, "R7 only fetch while request low", 32'(ntx - t0), 32'h4);
      chk(active_o == 1'b1, "R7 channel waiting", 32'(active_o), 32'h1);
      dreq_i = 1'b1;
      wait_idle();
      chk(eq_addr.size() == 0, "R7 completes after request", 32'(eq_addr.size()), 32'h0);
      wr(2'd2, 32'h50);

      // R5: chain of two descriptors ending at one without valid
      set_desc(DESC, 32'h0, 32'h80C, 32'hC4C, 32'h240);
      set_desc(32'h240, xf(1, 1, 2'd2, 1, 1, 2), 32'h81C, 32'hCAC, 32'h260);
      set_desc(32'h260, 32'h0, 32'h800, 32'hF00, 32'h0);
      run_plain(xf(1, 0, 2'd2, 1, 1, 3), "R5 chain ends at invalid descriptor");
      chk(edone == 2, "R5 two descriptors completed", 32'(edone), 32'h2);

      // R9: endless ping-pong loop stopped by clearing enable
      set_desc(DESC, 32'h0, 32'h900, 32'hD40, 32'h280);
      set_desc(32'h280, xf(1, 0, 2'd2, 0, 0, 0), 32'h8F0, 32'hD80, 32'h290);
      set_desc(32'h290, xf(1, 1, 2'd2, 1, 1, 3), 32'h90C, 32'hD4C, 32'h280);
      plan(xf(1, 0, 2'd2, 1, 1, 3), 3000);
      d0 = ndone;
      wr(2'd3, xf(1, 0, 2'd2, 1, 1, 3));
      begin
         int n = 0;
         while (ndone - d0 < 7 && n < 5000) begin
            @(negedge clk);
            n++;
         end
      end
      chk(ndone - d0 >= 7, "R5 loop keeps reloading", 32'(ndone - d0), 32'h7);
      wr(2'd0, 32'h0);
      wait_idle();
      chk(active_o == 1'b0, "R9 abort clears active", 32'(active_o), 32'h0);
      t0 = ntx; d0 = ndone;
      repeat (40) @(negedge clk);
      chk(ntx == t0 && ndone == d0, "R9 no access after abort", 32'(ntx - t0), 32'h0);

      // R8: starts that are refused
      eq_addr.delete(); eq_wr.delete(); eq_data.delete();
      wr(2'd3, xf(0, 0, 2'd2, 1, 1, 1));     // enable is clear
      repeat (20) @(negedge clk);
      chk(ntx == t0 && !active_o, "R8 ignored while disabled", 32'(ntx - t0), 32'h0);
      wr(2'd0, 32'h1);
      wr(2'd3, xf(0, 0, 2'd2, 1, 1, 1) & ~32'h1);   // valid bit clear
      repeat (20) @(negedge clk);
      chk(ntx == t0 && !active_o, "R8 ignored without valid", 32'(ntx - t0), 32'h0);

      // channel still usable afterwards
      set_desc(DESC, 32'h0, 32'h850, 32'hC90, 32'h0);
      run_plain(xf(0, 1, 2'd2, 1, 1, 2), "R2 restart after refusals");

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule